// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block takes one command-register write (a 16-bit command word plus a 32-bit argument) and turns it into a command request for the CMD-line serializer. It then waits for that serializer to report the card's response through a one-cycle handshake. It checks the response against the enables carried in the command word and either raises errors or stores the response payload in four 32-bit words. Short responses go to word 0. The 136-bit response is realigned one byte to the left across all four words.

The block keeps two busy flags. The command-busy flag lasts from an accepted write until the command finishes or is aborted. The data-line-busy flag covers a command that uses the data line, from its issue until the data engine reports the end of the transfer. A command that needs the data line is held until that line is free. The status and error words are write-one-to-clear.

Top module: `sdc_cmd_issue`

## Requirements
- R1: Command word fields: index at bits 13:8, response select at bits 1:0, CRC check enable at bit 3, index check enable at bit 4, data present at bit 5. An accepted write drives `issue_valid` high for exactly one cycle, two clock edges after the write. While it is high, `issue_index`, `issue_arg` and `issue_rsel` show the written fields.
- R2: A write is accepted only while `cmd_inh` is low, and `cmd_inh` is high from the edge after the write. A write made while `cmd_inh` is high is ignored: it changes neither the issued fields nor the number of issues.
- R3: A command needs the data line when data present is set or when the response select is 11 (48-bit with busy). Such a command is not issued while `dat_inh` is high. `dat_inh` goes high at the edge on which it is issued.
- R4: Response select 00 (no response) sets command complete (`norm_sts` bit 0) and clears `cmd_inh` at the issue edge, and leaves `resp_data` unchanged.
- R5: On a clean 48-bit response (select 10 or 11), `resp_data` becomes `{96'b0, rsp_payload[31:0]}`, command complete is set and `cmd_inh` clears, all at the response edge.
- R6: On a clean 136-bit response (select 01), `resp_data` becomes `{rsp_payload[119:0], 8'h00}`, so each word takes the top byte of the word below it.
- R7: Response errors set these bits of `err_sts`:
  - bit 0 on timeout, which suppresses every other response error;
  - bit 2 on an end-bit fault, always;
  - bit 1 on a CRC fault, only when the CRC check is enabled;
  - bit 3 when `rsp_index` differs from the command index, only when the index check is enabled.
- R8: A response with any error sets neither command complete nor `resp_data`, and clears both `cmd_inh` and `dat_inh`.
- R9: `xfer_done` while `dat_inh` is high sets transfer complete (`norm_sts` bit 1) and clears `dat_inh`. While `dat_inh` is low, `xfer_done` has no effect.
- R10: While `dat_inh` is high, data timeout, CRC and end-bit faults set `err_sts` bits 4, 5 and 6 and clear `dat_inh`. `aux_err[2:0]` sets `err_sts` bits 9:7 (current limit, auto-stop, DMA), aborts the command in flight and clears both busy flags.
- R11: A one in `nsts_clr` or `ests_clr` clears the matching status bit. A set event in the same cycle takes priority over the clear.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 16 | Command word (index, checks, data flag, response select) |
| cmd_arg | input | 32 | Command argument |
| issue_valid | output | 1 | One-cycle request to the CMD-line serializer |
| issue_index | output | 6 | Index of the issued command |
| issue_arg | output | 32 | Argument of the issued command |
| issue_rsel | output | 2 | Response select of the issued command |
| rsp_valid | input | 1 | Response report from the serializer |
| rsp_index | input | 6 | Index field received in the response |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_bad | input | 1 | Response CRC mismatch |
| rsp_end_bad | input | 1 | Response end bit was zero |
| rsp_payload | input | 120 | Response content without start, index and CRC fields |
| xfer_done | input | 1 | Data engine reports the end of the transfer or busy |
| dat_timeout | input | 1 | Data timeout fault |
| dat_crc_bad | input | 1 | Data CRC fault |
| dat_end_bad | input | 1 | Data end-bit fault |
| aux_err | input | 3 | Current-limit, auto-stop and DMA faults |
| nsts_clr | input | 2 | Write-one-to-clear mask for `norm_sts` |
| ests_clr | input | 10 | Write-one-to-clear mask for `err_sts` |
| cmd_inh | output | 1 | Command busy |
| dat_inh | output | 1 | Data line busy |
| norm_sts | output | 2 | Bit 0 command complete, bit 1 transfer complete |
| err_sts | output | 10 | Error status |
| resp_data | output | 128 | Four stored response words, word 0 in the low bits |

## Verification
The assertions assume that the serializer reports a response only for an issued command that expects one. They also assume that `xfer_done` and the data fault inputs stand for activity on a data line that this block has marked busy, and that the fault inputs are one-cycle pulses. The bench raises `rsp_valid` only after it has seen `issue_valid` for a command whose select is not 00, holds each handshake and fault input for a single edge, and pulses `xfer_done` with `dat_inh` low only in the case that checks it is ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W  = 6;
  localparam int CMDW_W = 16;
  localparam int ERR_W  = 10;
  localparam int RERR_W = 4;

  localparam logic [1:0] RSEL_NONE  = 2'b00;
  localparam logic [1:0] RSEL_LONG  = 2'b01;
  localparam logic [1:0] RSEL_SHORT = 2'b10;
  localparam logic [1:0] RSEL_BUSY  = 2'b11;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PEND = 2'd1, ST_WAIT = 2'd2} cmd_state_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             dat;
    logic             idx_chk;
    logic             crc_chk;
    logic [1:0]       rsel;
  } cmd_fields_t;

  function automatic cmd_fields_t decode_cmd(input logic [CMDW_W-1:0] w);
    cmd_fields_t f;
    f.idx     = w[13:8];
    f.dat     = w[5];
    f.idx_chk = w[4];
    f.crc_chk = w[3];
    f.rsel    = w[1:0];
    return f;
  endfunction

  function automatic logic needs_dat_line(input cmd_fields_t f);
    return f.dat || (f.rsel == RSEL_BUSY);
  endfunction

  // bit0 timeout, bit1 crc, bit2 end bit, bit3 index
  function automatic logic [RERR_W-1:0] rsp_err_bits(input logic timeout, input logic crc_bad,
                                                     input logic end_bad, input logic idx_bad,
                                                     input logic crc_chk, input logic idx_chk);
    logic [RERR_W-1:0] e;
    e = '0;
    if (timeout) e[0] = 1'b1;
    else begin
      e[1] = crc_bad & crc_chk;
      e[2] = end_bad;
      e[3] = idx_bad & idx_chk;
    end
    return e;
  endfunction
endpackage

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm import sdc_pkg::*; #(
  parameter int ARG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [CMDW_W-1:0]    cmd_word,
  input  logic [ARG_W-1:0]     cmd_arg,
  input  logic                 dat_inh,
  input  logic                 abort_ext,
  input  logic                 rsp_valid,
  input  logic [IDX_W-1:0]     rsp_index,
  input  logic                 rsp_timeout,
  input  logic                 rsp_crc_bad,
  input  logic                 rsp_end_bad,
  output logic                 cmd_inh,
  output logic                 issue_valid,
  output logic [IDX_W-1:0]     issue_index,
  output logic [ARG_W-1:0]     issue_arg,
  output logic [1:0]           issue_rsel,
  output logic                 issue_dat,
  output logic                 dat_start,
  output logic                 cmd_done_evt,
  output logic                 cap_evt,
  output logic                 rsp_err_evt,
  output logic [RERR_W-1:0]    rsp_err
);
  cmd_state_e        state_q, state_d;
  cmd_fields_t       fld_q;
  logic [ARG_W-1:0]  arg_q;
  logic              issue_q;
  logic              wr_accept, line_free, fire, rsp_seen;
  logic [RERR_W-1:0] ebits;

  assign wr_accept = cmd_wr && (state_q == ST_IDLE);
  assign line_free = !(needs_dat_line(fld_q) && dat_inh);
  assign fire      = (state_q == ST_PEND) && !abort_ext && line_free;
  assign ebits     = rsp_err_bits(rsp_timeout, rsp_crc_bad, rsp_end_bad,
                                  rsp_index != fld_q.idx, fld_q.crc_chk, fld_q.idx_chk);
  assign rsp_seen  = (state_q == ST_WAIT) && rsp_valid && !abort_ext;

  assign dat_start    = fire && needs_dat_line(fld_q);
  assign rsp_err_evt  = rsp_seen && (|ebits);
  assign rsp_err      = rsp_err_evt ? ebits : '0;
  assign cap_evt      = rsp_seen && !(|ebits);
  assign cmd_done_evt = cap_evt || (fire && fld_q.rsel == RSEL_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (wr_accept) state_d = ST_PEND;
      ST_PEND: begin
        if (abort_ext) state_d = ST_IDLE;
        else if (fire) state_d = (fld_q.rsel == RSEL_NONE) ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: if (abort_ext || rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fld_q   <= '0;
      arg_q   <= '0;
      issue_q <= 1'b0;
    end else begin
      state_q <= state_d;
      issue_q <= fire;
      if (wr_accept) begin
        fld_q <= decode_cmd(cmd_word);
        arg_q <= cmd_arg;
      end
    end
  end

  assign cmd_inh     = (state_q != ST_IDLE);
  assign issue_valid = issue_q;
  assign issue_index = fld_q.idx;
  assign issue_arg   = arg_q;
  assign issue_rsel  = fld_q.rsel;
  assign issue_dat   = needs_dat_line(fld_q);

  p_wr_sets_inh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !cmd_inh |=> cmd_inh);
  p_issue_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_valid) |-> $past(cmd_inh));
  p_dat_line_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_dat |-> !$past(dat_inh));
endmodule

// File: rtl/sdc_status.sv
module sdc_status import sdc_pkg::*; #(
  parameter int EW = ERR_W,
  localparam int AUX_W = EW - RERR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_done_evt,
  input  logic              dat_start,
  input  logic              rsp_err_evt,
  input  logic [RERR_W-1:0] rsp_err,
  input  logic              xfer_done,
  input  logic              dat_timeout,
  input  logic              dat_crc_bad,
  input  logic              dat_end_bad,
  input  logic [AUX_W-1:0]  aux_err,
  input  logic [1:0]        nsts_clr,
  input  logic [EW-1:0]     ests_clr,
  output logic              dat_inh,
  output logic [1:0]        norm_sts,
  output logic [EW-1:0]     err_sts
);
  logic          dat_inh_q;
  logic [1:0]    norm_q;
  logic [EW-1:0] err_q;
  logic [2:0]    dat_err;
  logic          abort, xfer_evt;

  assign dat_err  = dat_inh_q ? {dat_end_bad, dat_crc_bad, dat_timeout} : 3'b000;
  assign abort    = rsp_err_evt || (|aux_err);
  assign xfer_evt = dat_inh_q && xfer_done && !(|dat_err) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_inh_q <= 1'b0;
      norm_q    <= '0;
      err_q     <= '0;
    end else begin
      norm_q <= (norm_q & ~nsts_clr) | {xfer_evt, cmd_done_evt};
      err_q  <= (err_q & ~ests_clr) | {aux_err, dat_err, rsp_err};
      if (abort)                                       dat_inh_q <= 1'b0;
      else if (dat_start)                              dat_inh_q <= 1'b1;
      else if (dat_inh_q && (xfer_done || (|dat_err))) dat_inh_q <= 1'b0;
    end
  end

  assign dat_inh  = dat_inh_q;
  assign norm_sts = norm_q;
  assign err_sts  = err_q;

  p_xfer_needs_inh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(norm_sts[1]) |-> $past(dat_inh));
  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nsts_clr[0] && !cmd_done_evt |=> !norm_sts[0]);
endmodule

// File: rtl/sdc_resp_store.sv
module sdc_resp_store import sdc_pkg::*; #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int SHIFT   = 8,
  localparam int TOT    = WORD_W * N_WORDS,
  localparam int PAY_W  = TOT - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [1:0]       cap_rsel,
  input  logic [PAY_W-1:0] payload,
  output logic [TOT-1:0]   resp_data
);
  logic [TOT-1:0] long_v;
  assign long_v = {payload, {SHIFT{1'b0}}};

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] short_v;
    if (k == 0) begin : g_low
      assign short_v = payload[WORD_W-1:0];
    end else begin : g_high
      assign short_v = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (cap_evt) word_q <= (cap_rsel == RSEL_LONG) ? long_v[k*WORD_W +: WORD_W] : short_v;
    end
    assign resp_data[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue import sdc_pkg::*; #(
  parameter int ARG_W   = 32,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  localparam int TOT    = WORD_W * N_WORDS,
  localparam int PAY_W  = TOT - 8,
  localparam int AUX_W  = ERR_W - RERR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMDW_W-1:0] cmd_word,
  input  logic [ARG_W-1:0]  cmd_arg,
  output logic              issue_valid,
  output logic [IDX_W-1:0]  issue_index,
  output logic [ARG_W-1:0]  issue_arg,
  output logic [1:0]        issue_rsel,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_index,
  input  logic              rsp_timeout,
  input  logic              rsp_crc_bad,
  input  logic              rsp_end_bad,
  input  logic [PAY_W-1:0]  rsp_payload,
  input  logic              xfer_done,
  input  logic              dat_timeout,
  input  logic              dat_crc_bad,
  input  logic              dat_end_bad,
  input  logic [AUX_W-1:0]  aux_err,
  input  logic [1:0]        nsts_clr,
  input  logic [ERR_W-1:0]  ests_clr,
  output logic              cmd_inh,
  output logic              dat_inh,
  output logic [1:0]        norm_sts,
  output logic [ERR_W-1:0]  err_sts,
  output logic [TOT-1:0]    resp_data
);
  logic              issue_dat, dat_start, cmd_done_evt, cap_evt, rsp_err_evt;
  logic [RERR_W-1:0] rsp_err;

  sdc_cmd_fsm #(.ARG_W(ARG_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .dat_inh(dat_inh), .abort_ext(|aux_err), .rsp_valid(rsp_valid), .rsp_index(rsp_index),
    .rsp_timeout(rsp_timeout), .rsp_crc_bad(rsp_crc_bad), .rsp_end_bad(rsp_end_bad),
    .cmd_inh(cmd_inh), .issue_valid(issue_valid), .issue_index(issue_index),
    .issue_arg(issue_arg), .issue_rsel(issue_rsel), .issue_dat(issue_dat),
    .dat_start(dat_start), .cmd_done_evt(cmd_done_evt), .cap_evt(cap_evt),
    .rsp_err_evt(rsp_err_evt), .rsp_err(rsp_err)
  );

  sdc_status #(.EW(ERR_W)) u_status (
    .clk(clk), .rst_n(rst_n), .cmd_done_evt(cmd_done_evt), .dat_start(dat_start),
    .rsp_err_evt(rsp_err_evt), .rsp_err(rsp_err), .xfer_done(xfer_done),
    .dat_timeout(dat_timeout), .dat_crc_bad(dat_crc_bad), .dat_end_bad(dat_end_bad),
    .aux_err(aux_err), .nsts_clr(nsts_clr), .ests_clr(ests_clr),
    .dat_inh(dat_inh), .norm_sts(norm_sts), .err_sts(err_sts)
  );

  sdc_resp_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .SHIFT(8)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cap_rsel(issue_rsel),
    .payload(rsp_payload), .resp_data(resp_data)
  );

  p_err_keeps_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_evt |=> $stable(resp_data) && !cmd_inh);
  p_done_frees_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(norm_sts[0]) |-> !cmd_inh);
endmodule

// File: tb/test_sdc_cmd_issue.sv
`timescale 1ns/1ps
module test_sdc_cmd_issue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         cmd_wr = 0;
  logic [15:0]  cmd_word = 0;
  logic [31:0]  cmd_arg = 0;
  logic         issue_valid;
  logic [5:0]   issue_index;
  logic [31:0]  issue_arg;
  logic [1:0]   issue_rsel;
  logic         rsp_valid = 0;
  logic [5:0]   rsp_index = 0;
  logic         rsp_timeout = 0, rsp_crc_bad = 0, rsp_end_bad = 0;
  logic [119:0] rsp_payload = 0;
  logic         xfer_done = 0, dat_timeout = 0, dat_crc_bad = 0, dat_end_bad = 0;
  logic [2:0]   aux_err = 0;
  logic [1:0]   nsts_clr = 0;
  logic [9:0]   ests_clr = 0;
  logic         cmd_inh, dat_inh;
  logic [1:0]   norm_sts;
  logic [9:0]   err_sts;
  logic [127:0] resp_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [119:0] P1 = 120'h23_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [119:0] P2 = 120'hB2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90;
  localparam logic [119:0] P3 = 120'h11_2233_4455_6677_8899_AABB_CCDD_EEFF;
  logic [127:0] p2_long;

  sdc_cmd_issue i_sdc_cmd_issue (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr_all;
    nsts_clr = 2'b11; ests_clr = '1; tick; nsts_clr = 0; ests_clr = 0;
  endtask

  task automatic issue_cmd(input logic [15:0] w, input logic [31:0] a, input string req);
    cmd_wr = 1; cmd_word = w; cmd_arg = a; tick; cmd_wr = 0;
    chk(req, "busy after write", cmd_inh, 1);
    tick;
    chk(req, "issue pulse", issue_valid, 1);
    chk(req, "issued index", issue_index, w[13:8]);
    chk(req, "issued arg", issue_arg, a);
  endtask

  task automatic respond(input logic [5:0] idx, input logic [119:0] p, input logic to, input logic crc, input logic eb);
    rsp_valid = 1; rsp_index = idx; rsp_payload = p; rsp_timeout = to; rsp_crc_bad = crc; rsp_end_bad = eb;
    tick;
    rsp_valid = 0; rsp_timeout = 0; rsp_crc_bad = 0; rsp_end_bad = 0;
  endtask

  task automatic t_reset;
    chk("R12", "cmd_inh", cmd_inh, 0);
    chk("R12", "dat_inh", dat_inh, 0);
    chk("R12", "norm", norm_sts, 0);
    chk("R12", "err", err_sts, 0);
    chk("R12", "resp", resp_data, 0);
    chk("R12", "issue", issue_valid, 0);
  endtask

  task automatic t_short;
    issue_cmd(16'h111A, 32'hDEADBEEF, "R1");
    chk("R1", "issued select", issue_rsel, 2'b10);
    tick;
    chk("R1", "pulse one cycle", issue_valid, 0);
    nsts_clr = 2'b01;
    respond(6'h11, P1, 0, 0, 0);
    nsts_clr = 0;
    chk("R11", "set beats clear", norm_sts, 2'b01);
    chk("R5", "short word", resp_data, {96'b0, P1[31:0]});
    chk("R5", "not busy", cmd_inh, 0);
    nsts_clr = 2'b01; tick; nsts_clr = 0;
    chk("R11", "w1c", norm_sts, 0);
  endtask

  task automatic t_long;
    issue_cmd(16'h0209, 32'h0, "R6");
    respond(6'h3F, P2, 0, 0, 0);
    chk("R6", "realigned", resp_data, p2_long);
    chk("R7", "index unchecked", err_sts, 0);
    chk("R6", "complete", norm_sts, 2'b01);
    clr_all;
  endtask

  task automatic t_noresp;
    cmd_wr = 1; cmd_word = 16'h0000; cmd_arg = 32'h5; tick; cmd_wr = 0;
    tick;
    chk("R4", "issued", issue_valid, 1);
    chk("R4", "complete at issue", norm_sts, 2'b01);
    chk("R4", "not busy", cmd_inh, 0);
    chk("R4", "resp kept", resp_data, p2_long);
    clr_all;
  endtask

  task automatic t_ignore;
    cmd_wr = 1; cmd_word = 16'h111A; cmd_arg = 32'hA; tick;
    cmd_word = 16'h2A1A; cmd_arg = 32'hB; tick; cmd_wr = 0;
    chk("R2", "first kept index", issue_index, 6'h11);
    chk("R2", "first kept arg", issue_arg, 32'hA);
    respond(6'h11, P1, 0, 0, 0);
    chk("R2", "free", cmd_inh, 0);
    tick; tick;
    chk("R2", "no second issue", issue_valid, 0);
    chk("R2", "still free", cmd_inh, 0);
    clr_all;
  endtask

  task automatic t_errs;
    issue_cmd(16'h111A, 0, "R7");
    respond(6'h11, P3, 0, 1, 0);
    chk("R7", "crc err", err_sts, 10'h002);
    chk("R8", "no complete", norm_sts, 0);
    chk("R8", "free", cmd_inh, 0);
    chk("R8", "resp kept", resp_data, {96'b0, P1[31:0]});
    clr_all;
    issue_cmd(16'h0512, 0, "R7");
    respond(6'h05, P3, 0, 1, 0);
    chk("R7", "crc unchecked", err_sts, 0);
    chk("R7", "complete", norm_sts, 2'b01);
    chk("R5", "captured", resp_data, {96'b0, P3[31:0]});
    clr_all;
    issue_cmd(16'h111A, 0, "R7");
    respond(6'h12, P1, 0, 0, 0);
    chk("R7", "index err", err_sts, 10'h008);
    clr_all;
    issue_cmd(16'h111A, 0, "R7");
    respond(6'h11, P1, 1, 1, 1);
    chk("R7", "timeout only", err_sts, 10'h001);
    clr_all;
    issue_cmd(16'h1102, 0, "R7");
    respond(6'h11, P1, 0, 0, 1);
    chk("R7", "end bit", err_sts, 10'h004);
    clr_all;
  endtask

  task automatic t_data;
    issue_cmd(16'h123A, 32'h1, "R3");
    chk("R3", "data busy", dat_inh, 1);
    respond(6'h12, P1, 0, 0, 0);
    chk("R3", "cmd done, data busy", {norm_sts, dat_inh}, 3'b011);
    cmd_wr = 1; cmd_word = 16'h183A; cmd_arg = 32'h2; tick; cmd_wr = 0;
    tick;
    chk("R3", "held", issue_valid, 0);
    tick;
    chk("R3", "still held", issue_valid, 0);
    xfer_done = 1; tick; xfer_done = 0;
    chk("R9", "xfer complete", norm_sts, 2'b11);
    chk("R9", "line free", dat_inh, 0);
    tick;
    chk("R3", "released issue", issue_valid, 1);
    chk("R3", "released index", issue_index, 6'h18);
    chk("R3", "busy again", dat_inh, 1);
    respond(6'h18, P1, 0, 0, 0);
    clr_all;
    dat_crc_bad = 1; tick; dat_crc_bad = 0;
    chk("R10", "data crc", err_sts, 10'h020);
    chk("R10", "line free", dat_inh, 0);
    chk("R10", "no xfer", norm_sts, 0);
    clr_all;
    xfer_done = 1; tick; xfer_done = 0;
    chk("R9", "ignored", norm_sts, 0);
    issue_cmd(16'h0C1B, 0, "R3");
    chk("R3", "busy select uses line", dat_inh, 1);
    respond(6'h0C, P1, 0, 0, 0);
    xfer_done = 1; tick; xfer_done = 0;
    chk("R9", "both complete", norm_sts, 2'b11);
    clr_all;
  endtask

  task automatic t_aux;
    issue_cmd(16'h123A, 0, "R10");
    aux_err = 3'b100; tick; aux_err = 0;
    chk("R10", "dma err", err_sts, 10'h200);
    chk("R10", "cmd free", cmd_inh, 0);
    chk("R10", "line free", dat_inh, 0);
    clr_all;
    issue_cmd(16'h111A, 0, "R10");
    aux_err = 3'b010; tick; aux_err = 0;
    chk("R10", "auto-stop err", err_sts, 10'h100);
    chk("R10", "no complete", norm_sts, 0);
    clr_all;
  endtask

  initial begin
    p2_long = {8'h00, P2} * 128'd256;
    tick; tick;
    t_reset;
    rst_n = 1;
    tick;
    t_short;
    t_long;
    t_noresp;
    t_ignore;
    t_errs;
    t_data;
    t_aux;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule